// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block raises an interrupt at a fixed rate that software can program. It counts ticks of a slow 32768 Hz reference. The reference reaches the block as a one-cycle enable strobe that is already in the system clock domain. Once the selected number of ticks has gone by, the block sets an event flag. The flag stays set until software clears it by writing a one to it.

Software reaches the block through a byte-wide register port with a two-bit offset. Four registers sit behind it:

| Offset | Register | Contents |
|---|---|---|
| 0 | Control | Run bit and a four-bit period exponent |
| 1 | Status | Placeholder, always reads zero |
| 2 | Interrupt enable | Interrupt enable bit |
| 3 | Event flag | Event flag bit |

Each write to the control register starts the count again from zero under the new settings. The interrupt request output is the event flag gated by the interrupt enable bit.

Top module: `pit_timer`

## Requirements
- R1: While control bit 0 (run) is 1 and the period code in control bits [6:3] is between 1 and 14, the block counts `ref_tick` strobes and completes a period after 2^(code+1) strobes: 4 strobes for code 1 and 32768 strobes for code 14.
- R2: Control (offset 0) stores only bit 0 and bits [6:3]. Bits 1, 2 and 7 always read zero.
- R3: Bit 0 of the flag register (offset 3) reads 1 in the cycle after the clock edge that samples the strobe completing a period. Counting then continues from zero with no further write.
- R4: No period ever completes while run is 0, or while the period code is 0 or 15.
- R5: A write to offset 3 with data bit 0 set to 1 clears the flag. A write with data bit 0 set to 0 leaves the flag unchanged.
- R6: The status register (offset 1) always reads zero, and writes to it change no register.
- R7: Every write to offset 0 restarts the count at zero. A strobe that arrives in the same cycle as that write is not counted.
- R8: Offset 2 bit 0 is the interrupt enable. `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R9: A synchronous reset clears control, interrupt enable, flag and count, so every offset reads zero afterwards.
- R10: If a period completes in the same cycle as a write-one-to-clear of the flag, the flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per 32768 Hz reference tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge:
- **Period completion and flag clear.** The bench sets up a period so that its final strobe arrives in the same cycle as a write-one-to-clear. It passes only if the flag reads as set afterwards.
- **Strobe and control write.** A strobe that coincides with a control write must be dropped. The bench confirms this by counting how many strobes it takes after the restart before the flag appears.

A behavioural model runs alongside the design, and its read data and interrupt are compared with the design's on every clock.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Bus geometry
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;

    // Control register layout
    localparam int RUN_BIT   = 0;
    localparam int CODE_LSB  = 3;
    localparam int CODE_W    = 4;
    localparam int CODE_MSB  = CODE_LSB + CODE_W - 1;

    // Range of valid period codes
    localparam int MIN_CODE  = 1;
    localparam int MAX_CODE  = 14;

    // A counter of this width holds every count up to 2^(MAX_CODE+1)-1
    localparam int CNT_W     = MAX_CODE + 1;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL   = 2'd0,
        OFS_STATUS = 2'd1,
        OFS_IEN    = 2'd2,
        OFS_FLAG   = 2'd3
    } pit_ofs_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              run;
    } pit_ctrl_t;

    function automatic logic code_valid(input logic [CODE_W-1:0] code);
        return (code >= CODE_W'(MIN_CODE)) && (code <= CODE_W'(MAX_CODE));
    endfunction

    // Last count value of a period: 2^(code+1) - 1
    function automatic logic [CNT_W-1:0] period_last(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] one;
        one = CNT_W'(1);
        return (one << (code + CODE_W'(1))) - one;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input pit_ctrl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[RUN_BIT]           = c.run;
        b[CODE_MSB:CODE_LSB] = c.code;
        return b;
    endfunction

    function automatic pit_ctrl_t byte_to_ctrl(input logic [DATA_W-1:0] b);
        pit_ctrl_t c;
        c.run  = b[RUN_BIT];
        c.code = b[CODE_MSB:CODE_LSB];
        return c;
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              expire,
    output pit_ctrl_t         ctrl_q,
    output logic              ien_q,
    output logic              flag_q,
    output logic              restart,
    output logic [DATA_W-1:0] bus_rdata
);

    logic wr_ctrl;
    logic wr_ien;
    logic clr_flag;

    assign wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_ien   = bus_wr && (bus_addr == OFS_IEN);
    assign clr_flag = bus_wr && (bus_addr == OFS_FLAG) && bus_wdata[0];
    assign restart  = wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= byte_to_ctrl(bus_wdata);
            end
            if (wr_ien) begin
                ien_q <= bus_wdata[0];
            end
            // A new event takes priority over a clear in the same cycle
            if (expire) begin
                flag_q <= 1'b1;
            end else if (clr_flag) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_to_byte(ctrl_q);
            OFS_STATUS: bus_rdata = '0;
            OFS_IEN:    bus_rdata[0] = ien_q;
            OFS_FLAG:   bus_rdata[0] = flag_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             restart,
    input  pit_ctrl_t        ctrl,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    logic             active;
    logic             at_last;
    logic [CNT_W-1:0] last_val;

    assign last_val = period_last(ctrl.code);
    assign active   = ctrl.run && code_valid(ctrl.code);
    assign at_last  = (cnt_q == last_val);
    assign expire   = active && ref_tick && !restart && at_last;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (active && ref_tick) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    pit_ctrl_t        ctrl_q;
    logic             ien_q;
    logic             flag_q;
    logic             restart;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;

    pit_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expire    (expire),
        .ctrl_q    (ctrl_q),
        .ien_q     (ien_q),
        .flag_q    (flag_q),
        .restart   (restart),
        .bus_rdata (bus_rdata)
    );

    pit_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .restart  (restart),
        .ctrl     (ctrl_q),
        .cnt_q    (cnt_q),
        .expire   (expire)
    );

    assign irq = flag_q & ien_q;

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              expire,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q,
    input logic              ien_q,
    input logic              run,
    input logic [CODE_W-1:0] code
);

    p_status_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_STATUS) |-> (bus_rdata == '0));

    p_off_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (!run || code == '0 || code == '1) |-> !expire);

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL) |=> (cnt_q == '0));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_FLAG && bus_wdata[0] && !expire) |=> !flag_q);

    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!expire && !(bus_wr && bus_addr == OFS_FLAG && bus_wdata[0]))
        |=> (flag_q == $past(flag_q)));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q && flag_q));

    p_irq_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (ien_q && flag_q) |-> irq);

endmodule

bind pit_timer pit_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .expire    (expire),
    .cnt_q     (cnt_q),
    .flag_q    (flag_q),
    .ien_q     (ien_q),
    .run       (ctrl_q.run),
    .code      (ctrl_q.code)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_tick;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_timer dut (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Behavioural reference model
    int m_run, m_code, m_ien, m_flag, m_cnt, m_per, m_ev;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_code = 0; m_ien = 0; m_flag = 0; m_cnt = 0;
        end else begin
            m_ev  = 0;
            m_per = (m_code >= 1 && m_code <= 14) ? (1 << (m_code + 1)) : 0;
            if (bus_wr && bus_addr == 2'd0) begin
                m_run  = bus_wdata[0];
                m_code = bus_wdata[6:3];
                m_cnt  = 0;
            end else if (m_run != 0 && m_per != 0 && ref_tick) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == m_per) begin
                    m_cnt = 0;
                    m_ev  = 1;
                end
            end
            if (bus_wr && bus_addr == 2'd2) m_ien = bus_wdata[0];
            if (bus_wr && bus_addr == 2'd3 && bus_wdata[0]) m_flag = 0;
            if (m_ev != 0) m_flag = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int exp_rd;
        string tag;
        case (bus_addr)
            2'd0: begin exp_rd = m_run | (m_code << 3); tag = "R2 ctrl read"; end
            2'd1: begin exp_rd = 0;                     tag = "R6 status read"; end
            2'd2: begin exp_rd = m_ien;                 tag = "R8 ien read"; end
            default: begin exp_rd = m_flag;             tag = "R3 flag read"; end
        endcase
        check(bus_rdata == exp_rd[7:0], tag, bus_rdata, exp_rd);
        check(irq == ((m_flag & m_ien) != 0), "R8 irq", irq, m_flag & m_ien);
    endtask

    task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d, input bit t);
        bus_wr = w; bus_addr = a; bus_wdata = d; ref_tick = t;
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(input int n, input int every);
        for (int i = 0; i < n; i++) step(0, 2'd3, 8'h00, (i % every) == 0);
    endtask

    initial begin
        #(CLK_PERIOD * 120000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ref_tick = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9: reset state at every offset
        for (int a = 0; a < 4; a++) begin
            step(0, a[1:0], 8'h00, 1);
            check(bus_rdata == 8'h00, "R9 reset read", bus_rdata, 0);
        end

        // R2 / R4: unused bits, code 15 is off
        step(1, 2'd0, 8'hFF, 0);
        step(0, 2'd0, 8'h00, 0);
        check(bus_rdata == 8'h79, "R2 unused bits zero", bus_rdata, 8'h79);
        ticks(40, 1);
        check(bus_rdata[0] == 1'b0, "R4 code15 no event", bus_rdata, 0);
        step(1, 2'd0, 8'h01, 0);   // code 0, running
        ticks(40, 1);
        check(bus_rdata[0] == 1'b0, "R4 code0 no event", bus_rdata, 0);
        step(1, 2'd0, 8'h08, 0);   // code 1, stopped
        ticks(40, 1);
        check(bus_rdata[0] == 1'b0, "R4 stopped no event", bus_rdata, 0);

        // R6: status write ignored
        step(1, 2'd1, 8'hFF, 0);
        step(0, 2'd1, 8'h00, 0);
        check(bus_rdata == 8'h00, "R6 status zero", bus_rdata, 0);
        step(0, 2'd0, 8'h00, 0);
        check(bus_rdata == 8'h08, "R6 ctrl unchanged", bus_rdata, 8'h08);

        // R1 / R3: code 1, four strobes
        step(1, 2'd2, 8'h01, 0);
        step(1, 2'd0, 8'h09, 0);
        ticks(3, 1);
        check(bus_rdata[0] == 1'b0, "R3 flag before 4th", bus_rdata, 0);
        step(0, 2'd3, 8'h00, 1);
        check(bus_rdata[0] == 1'b1, "R1 flag after 4th", bus_rdata, 1);
        check(irq == 1'b1, "R8 irq raised", irq, 1);

        // R5: write zero keeps, write one clears
        step(1, 2'd3, 8'hFE, 0);
        check(bus_rdata[0] == 1'b1, "R5 write0 keeps", bus_rdata, 1);
        step(1, 2'd3, 8'h01, 0);
        check(bus_rdata[0] == 1'b0, "R5 write1 clears", bus_rdata, 0);
        ticks(4, 1);
        check(bus_rdata[0] == 1'b1, "R3 auto reload", bus_rdata, 1);

        // R10: completion and clear together
        step(1, 2'd3, 8'h01, 0);
        step(1, 2'd0, 8'h09, 0);
        ticks(3, 1);
        step(1, 2'd3, 8'h01, 1);
        check(bus_rdata[0] == 1'b1, "R10 event wins", bus_rdata, 1);
        step(1, 2'd3, 8'h01, 0);
        check(bus_rdata[0] == 1'b0, "R10 later clear", bus_rdata, 0);

        // R8: interrupt masked
        step(1, 2'd2, 8'h00, 0);
        ticks(8, 1);
        check(irq == 1'b0, "R8 masked", irq, 0);
        check(bus_rdata[0] == 1'b1, "R8 flag still set", bus_rdata, 1);
        step(1, 2'd2, 8'h01, 0);
        step(1, 2'd3, 8'h01, 0);

        // R1: code 2 with sparse strobes
        step(1, 2'd0, 8'h11, 0);
        ticks(60, 3);

        // R7: restart, strobe in write cycle dropped
        step(1, 2'd3, 8'h01, 0);
        step(1, 2'd0, 8'h19, 0);
        ticks(10, 1);
        step(1, 2'd0, 8'h19, 1);
        ticks(15, 1);
        check(bus_rdata[0] == 1'b0, "R7 restart no early event", bus_rdata, 0);
        step(0, 2'd3, 8'h00, 1);
        check(bus_rdata[0] == 1'b1, "R7 event at 16", bus_rdata, 1);

        // R1: longest period
        step(1, 2'd3, 8'h01, 0);
        step(1, 2'd0, 8'h71, 0);
        ticks(32767, 1);
        check(bus_rdata[0] == 1'b0, "R1 code14 before", bus_rdata, 0);
        step(0, 2'd3, 8'h00, 1);
        check(bus_rdata[0] == 1'b1, "R1 code14 event", bus_rdata, 1);

        // R4: stop the timer
        step(1, 2'd3, 8'h01, 0);
        step(1, 2'd0, 8'h70, 0);
        ticks(100, 1);
        check(bus_rdata[0] == 1'b0, "R4 stop no event", bus_rdata, 0);

        // R9: reset mid-run
        step(1, 2'd0, 8'h09, 0);
        ticks(6, 1);
        rst = 1;
        step(0, 2'd0, 8'h00, 1);
        rst = 0;
        for (int a = 0; a < 4; a++) begin
            step(0, a[1:0], 8'h00, 0);
            check(bus_rdata == 8'h00, "R9 reset clears", bus_rdata, 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule